// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port on a simple word-addressed register bus. The data register sits in a window at the bottom of the address space, and the byte address of each access carries the pin mask in bits [9:2]. One write can therefore set, clear or load any subset of pins at once, with no read-modify-write sequence and no race against other agents that touch the same port. Reads use the same masking, so unselected pins read as zero.

Above the data window sit the per-pin control registers. One sets the direction. Three set how interrupts are detected: edge or level, one edge or both edges, and rising/high or falling/low. Further registers hold the interrupt enable, the raw and masked status, a write-one-to-clear register for latched edges, and a per-pin choice between software and peripheral control of the pad. Pin inputs are synchronized before any use. A single interrupt line is the OR of the masked status.

Bus accesses complete in one cycle with no stall and no back-pressure. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. All control and status pins are plain level signals.

Top module: `mgpio_port`

## Requirements
- R1: After reset every register reads 0. This means all pins are software-controlled inputs, edge sense is selected, interrupts are masked, `pin_oe` is 0 and `irq` is 0.
- R2: A write with `bus_addr` below 0x400 uses `bus_addr[9:2]` as a pin mask. Only output-register bits whose mask bit is 1 take the value of `bus_wdata`, and the other bits keep their value.
- R3: A read with `bus_addr` below 0x400 returns the pin value ANDed with the mask `bus_addr[9:2]`. The pin value is the output register bit for an output pin and the synchronized `pin_in` bit for an input pin, and `pin_in` appears at most 3 clock edges after it changes.
- R4: The direction register at 0x400 uses 1 for output and 0 for input. For a software-controlled pin, `pin_oe` equals the direction bit and `pin_out` equals the output register bit.
- R5: When the sense bit (0x404) is 0 and the both-edges bit (0x408) is 0, the polarity bit (0x40C) selects the edge: 1 for rising, 0 for falling. A matching edge sets that pin's bit in raw status (0x414) within 3 clock edges of the pin change, and the bit stays set until it is cleared.
- R6: When the both-edges bit is 1 in edge sense, both rising and falling edges set the raw status bit, whatever the polarity bit holds.
- R7: When the sense bit is 1, the raw status bit follows the synchronized pin level: it is 1 while the pin is high if polarity is 1, and 1 while the pin is low if polarity is 0. The clear register does not affect it.
- R8: Writing 1 to a bit of the clear register (0x41C) clears that pin's latched edge status. Writing 0 to a bit leaves it unchanged.
- R9: Masked status (0x418) equals raw status ANDed with the enable register (0x410), where 1 means enabled. `irq` is 1 exactly when masked status is non-zero.
- R10: A bit of 1 in the peripheral-select register (0x420) drives `pin_out` and `pin_oe` for that pin from `alt_out` and `alt_oe`.
- R11: Writes to raw status and masked status are ignored, and the clear register always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write enable, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Peripheral output levels |
| alt_oe | input | 8 | Peripheral output enables |
| irq | output | 1 | OR of the masked interrupt status |

## Verification
The bench fires masked writes and reads at the data window with random masks and data, and compares each result with a model of the output register. A design that ignored the mask would corrupt pins that were not selected, and one that forgot the AND on reads would leak unselected bits. Directed cases drive edges against each polarity and the both-edges mode, then confirm that a zero write to the clear register keeps a latched bit and that a one write removes it. A design that latched on the wrong edge, or cleared on any write, shows the wrong raw status. Level-sense pins are checked to track the input and to survive a clear, and the peripheral-select case mixes both pad sources on one port. A mux bug there would show in `pin_out` or `pin_oe`.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

  typedef enum logic [3:0] {
    RS_DIR    = 4'd0,
    RS_SENSE  = 4'd1,
    RS_BOTH   = 4'd2,
    RS_POL    = 4'd3,
    RS_IE     = 4'd4,
    RS_RAW    = 4'd5,
    RS_MASKED = 4'd6,
    RS_CLR    = 4'd7,
    RS_ALT    = 4'd8,
    RS_NONE   = 4'd15
  } reg_sel_e;

  // word index inside the control region -> register select
  function automatic reg_sel_e word_to_sel(input logic [3:0] w);
    case (w)
      4'd0:    return RS_DIR;
      4'd1:    return RS_SENSE;
      4'd2:    return RS_BOTH;
      4'd3:    return RS_POL;
      4'd4:    return RS_IE;
      4'd5:    return RS_RAW;
      4'd6:    return RS_MASKED;
      4'd7:    return RS_CLR;
      4'd8:    return RS_ALT;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mgpio_detect.sv
module mgpio_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic s_now,   // synchronized pin level
  input  logic sense,   // 1 = level, 0 = edge
  input  logic both,    // 1 = either edge
  input  logic pol,     // 1 = rising / high
  input  logic clr,     // write-one-to-clear pulse
  output logic raw
);
  logic s_prev;
  logic edge_q;
  logic rise, fall, pick, trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= 1'b0;
    else        s_prev <= s_now;
  end

  always_comb begin
    rise = s_now & ~s_prev;
    fall = ~s_now & s_prev;
    if (both) pick = rise | fall;
    else      pick = pol ? rise : fall;
    trig = pick & ~sense;
  end

  // a new edge in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   edge_q <= 1'b0;
    else if (trig) edge_q <= 1'b1;
    else if (clr)  edge_q <= 1'b0;
  end

  assign raw = sense ? (pol ? s_now : ~s_now) : edge_q;

  // R5: a latch only sets after the synchronized level moved
  p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_q) |-> $past(s_now != s_prev));

  // R8: a clear with no competing edge empties the latch
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !trig) |=> !edge_q);

  // R7: level sense never sets the edge latch
  p_level_no_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sense |=> !$rose(edge_q));
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
  import mgpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic              irq
);
  localparam int WIN_BITS = NPINS + 2;   // data window spans 2^WIN_BITS bytes

  logic [NPINS-1:0] out_q, dir_q, sense_q, both_q, pol_q, ie_q, alt_q;
  logic [NPINS-1:0] pin_s, raw, masked, clr_pulse, mask, pin_val;
  logic             in_data, in_regs, data_wr;
  reg_sel_e         sel;

  // ---------------- address decode
  always_comb begin
    in_data = (bus_addr >> WIN_BITS) == ADDR_W'(0);
    in_regs = (bus_addr >> WIN_BITS) == ADDR_W'(1);
    mask    = bus_addr[WIN_BITS-1:2];
    if (in_regs && bus_addr[WIN_BITS-1:6] == '0) sel = word_to_sel(bus_addr[5:2]);
    else                                          sel = RS_NONE;
  end

  assign data_wr   = bus_we && in_data;
  assign clr_pulse = (bus_we && sel == RS_CLR) ? bus_wdata : '0;

  // ---------------- register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      alt_q   <= '0;
    end else begin
      if (data_wr) out_q <= (out_q & ~mask) | (bus_wdata & mask);
      if (bus_we) begin
        case (sel)
          RS_DIR:   dir_q   <= bus_wdata;
          RS_SENSE: sense_q <= bus_wdata;
          RS_BOTH:  both_q  <= bus_wdata;
          RS_POL:   pol_q   <= bus_wdata;
          RS_IE:    ie_q    <= bus_wdata;
          RS_ALT:   alt_q   <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  // ---------------- input path
  mgpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    mgpio_detect u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .s_now (pin_s[i]),
      .sense (sense_q[i]),
      .both  (both_q[i]),
      .pol   (pol_q[i]),
      .clr   (clr_pulse[i]),
      .raw   (raw[i])
    );
  end

  assign masked = raw & ie_q;
  assign irq    = |masked;

  // ---------------- pad mux
  assign pin_out = (alt_q & alt_out) | (~alt_q & out_q);
  assign pin_oe  = (alt_q & alt_oe)  | (~alt_q & dir_q);

  // ---------------- read mux
  assign pin_val = (dir_q & out_q) | (~dir_q & pin_s);

  always_comb begin
    bus_rdata = '0;
    if (in_data) bus_rdata = pin_val & mask;
    else begin
      case (sel)
        RS_DIR:    bus_rdata = dir_q;
        RS_SENSE:  bus_rdata = sense_q;
        RS_BOTH:   bus_rdata = both_q;
        RS_POL:    bus_rdata = pol_q;
        RS_IE:     bus_rdata = ie_q;
        RS_RAW:    bus_rdata = raw;
        RS_MASKED: bus_rdata = masked;
        RS_ALT:    bus_rdata = alt_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R2: unmasked output bits hold across a data write
  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((out_q ^ $past(out_q)) & ~$past(mask)) == '0);

  // R2: no data write, no output change
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(out_q));

  // R9: the interrupt needs an enabled pin
  p_irq_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q != '0);
endmodule

// File: tb/mgpio_port_tb.sv
`timescale 1ns/1ps
module mgpio_port_tb;
  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
    A_POL = 12'h40C, A_IE = 12'h410, A_RAW = 12'h414, A_MASKED = 12'h418,
    A_CLR = 12'h41C, A_ALT = 12'h420;

  logic        clk = 0, rst_n = 0, we = 0;
  logic [11:0] addr = '0;
  logic [7:0]  wd = '0, pins = '0, aout = '0, aoe = '0, rdv, model;
  wire  [7:0]  rd, pout, poe;
  wire         irq;
  int          nvec = 0, nerr = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  mgpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rd), .pin_in(pins), .pin_out(pout), .pin_oe(poe),
    .alt_out(aout), .alt_oe(aoe), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wd = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we = 0;
    #1 d = rd;
  endtask

  task automatic setpins(input logic [7:0] v);
    @(negedge clk); pins = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] m, input logic [7:0] d);
    return (old & ~m) | (d & m);
  endfunction

  initial begin
    #800000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd13579));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdreg(A_DIR, rdv);   chk("R1 dir", rdv, 8'h00);
    rdreg(12'h3FC, rdv); chk("R1 data", rdv, 8'h00);
    rdreg(A_RAW, rdv);   chk("R1 raw", rdv, 8'h00);
    chk("R1 oe", poe, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R4 direction and full write
    wr(A_DIR, 8'hFF);
    wr(12'h3FC, 8'hA5);
    chk("R4 pin_out", pout, 8'hA5);
    chk("R4 pin_oe", poe, 8'hFF);
    rdreg(12'h3FC, rdv); chk("R3 full read", rdv, 8'hA5);
    // R2 masked writes
    wr(12'h03C, 8'h00); chk("R2 clear low nibble", pout, 8'hA0);
    wr(12'h300, 8'hFF); chk("R2 set top pair", pout, 8'hE0);
    rdreg(12'h0C0, rdv); chk("R3 masked read", rdv, 8'h20);

    // random masked writes and reads against a model
    model = 8'hE0;
    for (int i = 0; i < 300; i++) begin
      logic [7:0] m, d, r;
      m = 8'($urandom); d = 8'($urandom); r = 8'($urandom);
      wr({2'b00, m, 2'b00}, d);
      model = merge(model, m, d);
      rdreg({2'b00, r, 2'b00}, rdv);
      chk("R2/R3 random", rdv, model & r);
      if (i % 16 == 0) chk("R2 pin_out", pout, model);
    end

    // R3 input reads through the synchronizer
    wr(A_DIR, 8'h00);
    for (int i = 0; i < 50; i++) begin
      logic [7:0] p, r;
      p = 8'($urandom); r = 8'($urandom);
      @(negedge clk); pins = p;
      repeat (3) @(negedge clk);
      rdreg({2'b00, r, 2'b00}, rdv);
      chk("R3 input read", rdv, p & r);
    end
    setpins(8'h00);
    wr(A_CLR, 8'hFF);
    rdreg(A_RAW, rdv); chk("R8 all cleared", rdv, 8'h00);

    // R5 single edge with polarity
    wr(A_POL, 8'h01);
    wr(A_IE, 8'hFF);
    setpins(8'h03);
    rdreg(A_RAW, rdv); chk("R5 rising only", rdv, 8'h01);
    rdreg(A_MASKED, rdv); chk("R9 masked", rdv, 8'h01);
    chk("R9 irq", {7'b0, irq}, 8'h01);
    setpins(8'h00);
    rdreg(A_RAW, rdv); chk("R5 falling latched", rdv, 8'h03);
    // R8 clear
    wr(A_CLR, 8'h01);
    rdreg(A_RAW, rdv); chk("R8 clear one", rdv, 8'h02);
    wr(A_CLR, 8'h00);
    rdreg(A_RAW, rdv); chk("R8 zero no effect", rdv, 8'h02);
    // R11 read-only status
    wr(A_RAW, 8'hFF);
    rdreg(A_RAW, rdv); chk("R11 raw write ignored", rdv, 8'h02);
    wr(A_MASKED, 8'h00);
    rdreg(A_RAW, rdv); chk("R11 masked write ignored", rdv, 8'h02);
    rdreg(A_CLR, rdv); chk("R11 clear reads 0", rdv, 8'h00);
    // R9 enable
    wr(A_IE, 8'h01);
    rdreg(A_MASKED, rdv); chk("R9 masked off", rdv, 8'h00);
    chk("R9 irq off", {7'b0, irq}, 8'h00);
    wr(A_IE, 8'h02);
    chk("R9 irq on", {7'b0, irq}, 8'h01);
    wr(A_CLR, 8'h02);
    chk("R9 irq after clear", {7'b0, irq}, 8'h00);

    // R6 both edges (pin2, polarity 0)
    wr(A_POL, 8'h00);
    wr(A_BOTH, 8'h04);
    setpins(8'h04);
    rdreg(A_RAW, rdv); chk("R6 rise", rdv, 8'h04);
    wr(A_CLR, 8'h04);
    setpins(8'h00);
    rdreg(A_RAW, rdv); chk("R6 fall", rdv, 8'h04);
    wr(A_CLR, 8'hFF);

    // R7 level sense: pin4 high-active, pin5 low-active
    wr(A_SENSE, 8'h30);
    wr(A_POL, 8'h10);
    repeat (2) @(negedge clk);
    rdreg(A_RAW, rdv); chk("R7 low level", rdv, 8'h20);
    setpins(8'h10);
    rdreg(A_RAW, rdv); chk("R7 both levels", rdv, 8'h30);
    setpins(8'h30);
    rdreg(A_RAW, rdv); chk("R7 high only", rdv, 8'h10);
    wr(A_CLR, 8'hFF);
    rdreg(A_RAW, rdv); chk("R7 clear no effect", rdv, 8'h10);

    // R10 peripheral select
    wr(A_DIR, 8'hCC);
    wr(12'h3FC, 8'hF0);
    aout = 8'h05; aoe = 8'h0A;
    wr(A_ALT, 8'h0F);
    chk("R10 pin_out", pout, 8'hF5);
    chk("R10 pin_oe", poe, 8'hCA);
    wr(A_ALT, 8'h00);
    chk("R10 back to software", pout, 8'hF0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule